// File: doc/BRIEF.md
# Bit-Masked PHY Control Register Bank

This block holds a small set of 32-bit control registers that configure a serial receiver PHY: per-lane enables, forced line modes, turnaround controls, clock-inversion selects and the pins of a byte-wide test port. Each register stores 16 bits. The upper half of every write word carries a per-bit write-enable mask. Software can therefore change one field, or a single pin such as the test clock, without first reading the register and without disturbing the other fields.

The stored bits drive the PHY-side control outputs directly from flip-flops. One further address is read-only and returns the test port's 8-bit data output. A read or a write to an address that does not exist raises a one-cycle error pulse, and so does a write to the read-only address. Read data and the error flag are both registered, and both appear one cycle after the access.

Top module: `phy_ctl_regbank`

## Requirements
- R1: During and just after synchronous active-high reset, every control output, `rdata` and `acc_err` are zero.
- R2: On a write to a control register, stored bit i (0..15) takes `wdata[i]` when `wdata[i+16]` is 1 and otherwise keeps its value; a write with an all-zero mask changes nothing.
- R3: Address 0 holds the lane fields: bits 3:0 drive `lane_en`, 7:4 `force_rx`, 11:8 `force_stop`, 15:12 `turn_dis`.
- R4: Address 1 holds the turnaround request in bits 3:0 (`turn_req`), the first receiver's clock inversion in bit 10 (`rx0_clk_inv`) and the second receiver's in bit 11 (`rx1_clk_inv`).
- R5: Address 2 holds the test port: bits 7:0 drive `tst_din`, bit 8 `tst_en`, bit 9 `tst_clk`, bit 10 `tst_clr`.
- R6: A read of address 0, 1 or 2 returns the stored 16 bits in `rdata[15:0]` with `rdata[31:16]` zero, one cycle after `rd_en`. The value is the one stored before any write in the same cycle.
- R7: A read of address 3 returns `tst_dout` as sampled in the read cycle in `rdata[7:0]`, with all other bits zero.
- R8: A write to address 3 or to any address of 4 or above changes no stored bit and makes `acc_err` high for exactly the following cycle.
- R9: A read of any address of 4 or above returns zero and makes `acc_err` high for the following cycle. A valid access, or no access, leaves `acc_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data: [31:16] bit mask, [15:0] value |
| rdata | output | 32 | Registered read data |
| acc_err | output | 1 | One-cycle pulse for an invalid access |
| lane_en | output | 4 | Per-lane receiver enable |
| force_rx | output | 4 | Per-lane forced receive mode |
| force_stop | output | 4 | Per-lane forced stop state |
| turn_dis | output | 4 | Per-lane turnaround disable |
| turn_req | output | 4 | Per-lane turnaround request |
| rx0_clk_inv | output | 1 | Clock inversion, first receiver |
| rx1_clk_inv | output | 1 | Clock inversion, second receiver |
| tst_din | output | 8 | Test port data input |
| tst_en | output | 1 | Test port enable |
| tst_clk | output | 1 | Test port clock |
| tst_clr | output | 1 | Test port clear |
| tst_dout | input | 8 | Test port data output, readable at address 3 |

## Verification
The hardest case to reach from the ports is a write that must leave state untouched. A partial mask should leave the neighbouring fields alone, and a rejected write to the status or an unmapped address should change nothing. To reach it, the stimulus first loads distinctive non-zero patterns into every field. It then issues the narrow-mask, zero-mask and rejected writes, and reads each register back through the bus while also watching the output pins. The test port is driven bit by bit, toggling the clock pin alone as a driver would, to show that single-bit masks work.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned HALF_W  = BUS_W / 2;
  localparam int unsigned NUM_CTL = 3;
  localparam int unsigned LANES   = 4;
  localparam int unsigned TST_W   = 8;
  localparam int unsigned IDX_LANE = 0;
  localparam int unsigned IDX_TURN = 1;
  localparam int unsigned IDX_TEST = 2;
  localparam int unsigned IDX_STAT = 3;
  typedef logic [HALF_W-1:0] half_t;
endpackage

// File: rtl/phy_ctl_masked_reg.sv
module phy_ctl_masked_reg
  import phy_ctl_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  we,
  input  half_t val,
  input  half_t msk,
  output half_t q
);
  half_t q_r;

  always_ff @(posedge clk) begin
    if (rst)     q_r <= '0;
    else if (we) q_r <= (q_r & ~msk) | (val & msk);
  end

  assign q = q_r;
endmodule

// File: rtl/phy_ctl_decode.sv
module phy_ctl_decode
  import phy_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_CTL-1:0] wsel,
  output logic [NUM_CTL:0]   rsel,
  output logic               bad
);
  logic [NUM_CTL:0] hit;

  genvar g;
  generate
    for (g = 0; g <= NUM_CTL; g++) begin : g_hit
      assign hit[g] = (addr == ADDR_W'(g));
    end
  endgenerate

  always_comb begin
    wsel = wr_en ? hit[NUM_CTL-1:0] : '0;
    rsel = rd_en ? hit : '0;
    bad  = (wr_en && (hit[NUM_CTL-1:0] == '0)) || (rd_en && (hit == '0));
  end
endmodule

// File: rtl/phy_ctl_regbank.sv
module phy_ctl_regbank
  import phy_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              acc_err,
  output logic [3:0]        lane_en,
  output logic [3:0]        force_rx,
  output logic [3:0]        force_stop,
  output logic [3:0]        turn_dis,
  output logic [3:0]        turn_req,
  output logic              rx0_clk_inv,
  output logic              rx1_clk_inv,
  output logic [7:0]        tst_din,
  output logic              tst_en,
  output logic              tst_clk,
  output logic              tst_clr,
  input  logic [7:0]        tst_dout
);
  logic [NUM_CTL-1:0] wsel;
  logic [NUM_CTL:0]   rsel;
  logic               bad;
  half_t              store [NUM_CTL];
  half_t              rd_mux;
  logic [BUS_W-1:0]   rdata_r;
  logic               err_r;

  phy_ctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wsel(wsel), .rsel(rsel), .bad(bad)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_CTL; g++) begin : g_reg
      phy_ctl_masked_reg u_reg (
        .clk(clk), .rst(rst), .we(wsel[g]),
        .val(wdata[HALF_W-1:0]), .msk(wdata[BUS_W-1:HALF_W]),
        .q(store[g])
      );
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    for (int r = 0; r < NUM_CTL; r++)
      if (rsel[r]) rd_mux = store[r];
    if (rsel[IDX_STAT]) rd_mux = {{(HALF_W-TST_W){1'b0}}, tst_dout};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_r <= '0;
      err_r   <= 1'b0;
    end else begin
      rdata_r <= rd_en ? {{HALF_W{1'b0}}, rd_mux} : '0;
      err_r   <= bad;
    end
  end

  assign rdata   = rdata_r;
  assign acc_err = err_r;

  assign lane_en     = store[IDX_LANE][3:0];
  assign force_rx    = store[IDX_LANE][7:4];
  assign force_stop  = store[IDX_LANE][11:8];
  assign turn_dis    = store[IDX_LANE][15:12];
  assign turn_req    = store[IDX_TURN][3:0];
  assign rx0_clk_inv = store[IDX_TURN][10];
  assign rx1_clk_inv = store[IDX_TURN][11];
  assign tst_din     = store[IDX_TEST][7:0];
  assign tst_en      = store[IDX_TEST][8];
  assign tst_clk     = store[IDX_TEST][9];
  assign tst_clr     = store[IDX_TEST][10];
endmodule

// File: rtl/phy_ctl_regbank_chk.sv
module phy_ctl_regbank_chk #(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              acc_err,
  input logic [3:0]        lane_en,
  input logic [3:0]        force_rx,
  input logic [3:0]        force_stop,
  input logic [3:0]        turn_dis,
  input logic [3:0]        turn_req,
  input logic              rx0_clk_inv,
  input logic              rx1_clk_inv,
  input logic [7:0]        tst_din,
  input logic              tst_en,
  input logic              tst_clk,
  input logic              tst_clr,
  input logic [7:0]        tst_dout
);
  logic [15:0] lane_word, turn_word, test_word;
  assign lane_word = {turn_dis, force_stop, force_rx, lane_en};
  assign turn_word = {rx1_clk_inv, rx0_clk_inv, turn_req};
  assign test_word = {tst_clr, tst_clk, tst_en, tst_din};

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (lane_word == '0 && turn_word == '0 && test_word == '0 && rdata == '0 && !acc_err));

  // R2
  zero_mask_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(0) && wdata[31:16] == '0) |=> $stable(lane_word));

  // R6
  read_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(0)) |=> (rdata == {16'h0, $past(lane_word)}));

  // R7
  read_status_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(3)) |=> (rdata == {24'h0, $past(tst_dout)}));

  // R8
  bad_write_err_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr >= ADDR_W'(3)) |=> acc_err);

  // R8
  status_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(3)) |=> ($stable(lane_word) && $stable(turn_word) && $stable(test_word)));

  // R9
  idle_no_err_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !rd_en) |=> !acc_err);
endmodule

bind phy_ctl_regbank phy_ctl_regbank_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/phy_ctl_regbank_test.sv
module phy_ctl_regbank_test;
  localparam int unsigned ADDR_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic acc_err;
  logic [3:0] lane_en, force_rx, force_stop, turn_dis, turn_req;
  logic rx0_clk_inv, rx1_clk_inv, tst_en, tst_clk, tst_clr;
  logic [7:0] tst_din;
  logic [7:0] tst_dout = 8'h00;

  int n_chk = 0, n_bad = 0;
  logic [15:0] model [3];
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_seen = 1'b0;

  phy_ctl_regbank #(.ADDR_W(ADDR_W)) uut (.*);

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= rd_en;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, rdata, e);
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
    if (a < 3) model[a] = (model[a] & ~d[31:16]) | (d[15:0] & d[31:16]);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input string t);
    @(negedge clk);
    rd_en = 1'b1; addr = ADDR_W'(a);
    if (a < 3) exp_q.push_back({16'h0, model[a]});
    else if (a == 3) exp_q.push_back({24'h0, tst_dout});
    else exp_q.push_back(32'h0);
    tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic check_pins(input string t);
    check({t, " lane pins"}, {16'h0, turn_dis, force_stop, force_rx, lane_en}, {16'h0, model[0]});
    check({t, " turn pins"}, {26'h0, rx1_clk_inv, rx0_clk_inv, turn_req},
          {26'h0, model[1][11], model[1][10], model[1][3:0]});
    check({t, " test pins"}, {21'h0, tst_clr, tst_clk, tst_en, tst_din}, {21'h0, model[2][10:0]});
  endtask

  initial begin
    for (int i = 0; i < 3; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R1
    check_pins("R1");
    check("R1 rdata", rdata, 32'h0);
    check("R1 err", {31'h0, acc_err}, 32'h0);
    rst = 1'b0;

    // R3 / R2: fields one at a time
    wr(0, 32'h000F_000F);
    check("R9 no err on valid write", {31'h0, acc_err}, 32'h0);
    wr(0, 32'h00F0_0050);
    wr(0, 32'h0F00_FFFF);
    check_pins("R3");
    rd(0, "R6 lane read");
    wr(0, 32'h0000_0000);
    check_pins("R2 zero mask");
    wr(0, 32'hF000_A0FF);
    check_pins("R2 partial mask");
    wr(0, 32'h0001_0000);
    check("R2 single bit clear", {28'h0, lane_en}, 32'hE);
    rd(0, "R6 lane read after masks");

    // R4
    wr(1, 32'h0C0F_0C09);
    check_pins("R4");
    wr(1, 32'h0400_0000);
    check("R4 rx0 inv cleared", {30'h0, rx1_clk_inv, rx0_clk_inv}, 32'h2);
    rd(1, "R6 turn read");

    // R5: test port sequence, single-bit pin toggles
    wr(2, 32'h0200_0200);
    wr(2, 32'h0400_0400);
    wr(2, 32'h0400_0000);
    wr(2, 32'h01FF_0134);
    wr(2, 32'h0200_0000);
    check_pins("R5");
    wr(2, 32'h0100_0000);
    wr(2, 32'h00FF_00C7);
    wr(2, 32'h0200_0200);
    check_pins("R5 data phase");
    rd(2, "R6 test read");

    // R7
    tst_dout = 8'hA5;
    rd(3, "R7 status");
    tst_dout = 8'h3C;
    rd(3, "R7 status again");

    // R8: rejected writes
    @(negedge clk);
    wr_en = 1'b1; addr = ADDR_W'(3); wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    wr_en = 1'b0;
    check("R8 status write err", {31'h0, acc_err}, 32'h1);
    @(negedge clk);
    check("R8 err is one cycle", {31'h0, acc_err}, 32'h0);
    check_pins("R8 after status write");
    wr(7, 32'hFFFF_0000);
    check("R8 unmapped write err", {31'h0, acc_err}, 32'h1);
    wr(15, 32'hFFFF_FFFF);
    check_pins("R8 after unmapped write");
    rd(0, "R8 lane intact");
    rd(1, "R8 turn intact");
    rd(2, "R8 test intact");

    // R9
    rd(9, "R9 unmapped read");
    check("R9 read err", {31'h0, acc_err}, 32'h1);
    @(negedge clk);
    check("R9 err cleared", {31'h0, acc_err}, 32'h0);

    // R6: read and write in the same cycle returns old value
    @(negedge clk);
    rd_en = 1'b1; wr_en = 1'b1; addr = ADDR_W'(1); wdata = 32'h000F_0000;
    exp_q.push_back({16'h0, model[1]}); tag_q.push_back("R6 read-before-write");
    model[1] = model[1] & 16'hFFF0;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    check_pins("R6 after simultaneous");

    // R1: reset again clears everything
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 3; i++) model[i] = '0;
    @(negedge clk);
    rst = 1'b0;
    check_pins("R1 re-reset");
    rd(0, "R1 read after reset");

    repeat (2) @(negedge clk);
    check("scoreboard drained", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule